// File: doc/BRIEF.md
# Stream Cipher Key Scheduler

This block prepares the 256-byte permutation state used by a byte-oriented stream cipher. On request it writes the identity permutation into an internal single-port byte memory. It then makes one key-scheduling pass over that memory. For every position `i` from 0 to 255 it advances a running index `j` by the current entry and by one byte of a 24-bit secret key. It then exchanges the entries at `i` and `j`. The memory allows one access per clock cycle, so each exchange takes separate read and write cycles.

A caller starts the block with a ready/enable handshake. It waits for `ready` to rise again and does not count on a fixed latency. When the block is idle, the finished permutation can be read out through a synchronous inspection port. Keystream generation and message handling belong to other blocks.

Top module: `ksched_top`

## Requirements
- R1: While `rst_n` is low, and from the first idle cycle after it is released, `ready` is 1.
- R2: A cycle in which `ready` and `start_en` are both 1 is accepted as a start request, and `ready` is 0 in the very next cycle.
- R3: After an accepted start, `ready` stays 0 for exactly 1280 clock cycles: 256 fill cycles plus 4 cycles for each of the 256 exchange steps. It then returns to 1.
- R4: When the block is idle again, memory entry `n` holds the result of the following process. Set S[n]=n for every n, with j=0. Then, for i=0..255, set j=(j+S[i]+K[i mod 3]) mod 256 and swap S[i] with S[j]. All arithmetic uses 8-bit wrapping values.
- R5: The key byte order is K[0]=`key_in[23:16]`, K[1]=`key_in[15:8]` and K[2]=`key_in[7:0]`. The byte used cycles through 0, 1, 2 as i increases.
- R6: `key_in` is sampled only in the cycle the start is accepted. Changes to it while `ready` is 0 do not affect the result.
- R7: `start_en` pulses while `ready` is 0 are ignored. They neither shorten nor extend the run, and they do not change the result.
- R8: While `ready` is 1, `peek_data` shows the entry at the `peek_addr` value sampled at the previous clock edge. Reading never alters the memory.
- R9: Asserting `rst_n` low during a run aborts it and makes `ready` 1. A following start produces a complete, correct result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start_en | input | 1 | Start request, taken when `ready` is 1 |
| key_in | input | 24 | Secret key, most significant byte used first |
| ready | output | 1 | Block idle and able to accept a start |
| peek_addr | input | 8 | Inspection address, used while idle |
| peek_data | output | 8 | Entry at the previously sampled inspection address |

## Verification
A run's result is due when `ready` returns. That happens 1280 cycles after the accepting edge. The bench counts falling edges with `ready` low and requires exactly that count before it reads anything. Inspection data is due one edge after the address is presented. The bench therefore drives `peek_addr` on a falling edge and samples `peek_data` on the next falling edge, well away from the active edge. The whole array is then compared with a bench function that runs the key-scheduling process for the same key.

// File: rtl/ksched_pkg.sv
package ksched_pkg;
  localparam int BYTE_W    = 8;
  localparam int DEPTH     = 1 << BYTE_W;
  localparam int KEY_BYTES = 3;
  localparam int KEY_W     = KEY_BYTES * BYTE_W;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_FILL  = 3'd1,
    ST_RD_I  = 3'd2,
    ST_RD_J  = 3'd3,
    ST_WR_I  = 3'd4,
    ST_WR_J  = 3'd5
  } ks_state_t;
endpackage

// File: rtl/ksched_rst_sync.sv
module ksched_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= '0;
    else         chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign srst_n = chain_q[STAGES-1];
endmodule

// File: rtl/ksched_ram.sv
module ksched_ram #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 8,
  localparam int DEPTH = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
    rdata <= mem[addr];
  end
endmodule

// File: rtl/ksched_ctrl.sv
module ksched_ctrl
  import ksched_pkg::*;
#(
  parameter int DATA_W = BYTE_W,
  parameter int NKEY   = KEY_BYTES,
  localparam int KW    = NKEY * DATA_W,
  localparam int KIX_W = (NKEY > 1) ? $clog2(NKEY) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_en,
  input  logic [KW-1:0]     key_in,
  input  logic [DATA_W-1:0] ram_rdata,
  output logic              ram_we,
  output logic [DATA_W-1:0] ram_addr,
  output logic [DATA_W-1:0] ram_wdata,
  output logic              idle
);
  localparam logic [DATA_W-1:0] LAST    = '1;
  localparam logic [KIX_W-1:0]  KIX_TOP = KIX_W'(NKEY - 1);

  ks_state_t         state_q, state_d;
  logic [DATA_W-1:0] i_q, i_d, j_q, j_d, si_q, si_d;
  logic [KIX_W-1:0]  kix_q, kix_d;
  logic [KW-1:0]     key_q;
  logic              key_ld;
  logic [DATA_W-1:0] key_byte, j_next;

  always_comb begin
    key_byte = '0;
    for (int b = 0; b < NKEY; b++) begin
      if (kix_q == KIX_W'(b)) key_byte = key_q[(NKEY-1-b)*DATA_W +: DATA_W];
    end
  end

  assign j_next = j_q + ram_rdata + key_byte;

  always_comb begin
    state_d   = state_q;
    i_d       = i_q;
    j_d       = j_q;
    si_d      = si_q;
    kix_d     = kix_q;
    key_ld    = 1'b0;
    ram_we    = 1'b0;
    ram_addr  = i_q;
    ram_wdata = '0;
    unique case (state_q)
      ST_IDLE: begin
        if (start_en) begin
          state_d = ST_FILL;
          i_d     = '0;
          j_d     = '0;
          kix_d   = '0;
          key_ld  = 1'b1;
        end
      end
      ST_FILL: begin
        ram_we    = 1'b1;
        ram_wdata = i_q;
        i_d       = i_q + 1'b1;
        if (i_q == LAST) state_d = ST_RD_I;
      end
      ST_RD_I: begin
        state_d = ST_RD_J;
      end
      ST_RD_J: begin
        si_d     = ram_rdata;
        j_d      = j_next;
        ram_addr = j_next;
        state_d  = ST_WR_I;
      end
      ST_WR_I: begin
        ram_we    = 1'b1;
        ram_wdata = ram_rdata;
        state_d   = ST_WR_J;
      end
      ST_WR_J: begin
        ram_we    = 1'b1;
        ram_addr  = j_q;
        ram_wdata = si_q;
        i_d       = i_q + 1'b1;
        kix_d     = (kix_q == KIX_TOP) ? '0 : kix_q + 1'b1;
        state_d   = (i_q == LAST) ? ST_IDLE : ST_RD_I;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      i_q     <= '0;
      j_q     <= '0;
      si_q    <= '0;
      kix_q   <= '0;
    end else begin
      state_q <= state_d;
      i_q     <= i_d;
      j_q     <= j_d;
      si_q    <= si_d;
      kix_q   <= kix_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      key_q <= '0;
    else if (key_ld) key_q <= key_in;
  end

  assign idle = (state_q == ST_IDLE);

  AST_START_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE && start_en) |=> (state_q == ST_FILL)); // R2
  AST_BUSY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != ST_IDLE && !(state_q == ST_WR_J && i_q == LAST)) |=> (state_q != ST_IDLE)); // R3
  AST_FILL_TO_SWAP: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_FILL && i_q == LAST) |=> (state_q == ST_RD_I && i_q == '0)); // R4
  AST_KIX_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (kix_q <= KIX_TOP)); // R5
  AST_KIX_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_WR_J) |=> (kix_q == (($past(kix_q) == KIX_TOP) ? '0 : $past(kix_q) + 1'b1))); // R5
  AST_KEY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != ST_IDLE) |=> $stable(key_q)); // R6
endmodule

// File: rtl/ksched_top.sv
module ksched_top
  import ksched_pkg::*;
#(
  parameter int NKEY   = KEY_BYTES,
  localparam int KW    = NKEY * BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_en,
  input  logic [KW-1:0]     key_in,
  output logic              ready,
  input  logic [BYTE_W-1:0] peek_addr,
  output logic [BYTE_W-1:0] peek_data
);
  logic              srst_n;
  logic              ctl_we, ctl_idle;
  logic [BYTE_W-1:0] ctl_addr, ctl_wdata, ram_addr, ram_rdata;

  ksched_rst_sync #(.STAGES(2)) u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (srst_n)
  );

  ksched_ctrl #(.DATA_W(BYTE_W), .NKEY(NKEY)) u_ctrl (
    .clk       (clk),
    .rst_n     (srst_n),
    .start_en  (start_en),
    .key_in    (key_in),
    .ram_rdata (ram_rdata),
    .ram_we    (ctl_we),
    .ram_addr  (ctl_addr),
    .ram_wdata (ctl_wdata),
    .idle      (ctl_idle)
  );

  assign ram_addr = ctl_idle ? peek_addr : ctl_addr;

  ksched_ram #(.DATA_W(BYTE_W), .ADDR_W(BYTE_W)) u_ram (
    .clk   (clk),
    .we    (ctl_we),
    .addr  (ram_addr),
    .wdata (ctl_wdata),
    .rdata (ram_rdata)
  );

  assign ready     = ctl_idle;
  assign peek_data = ram_rdata;

  AST_IDLE_NO_WRITE: assert property (@(posedge clk) disable iff (!srst_n)
    ready |-> !ctl_we); // R8
  AST_RESET_READY: assert property (@(posedge clk)
    !srst_n |-> ready); // R1
endmodule

// File: tb/ksched_top_tb.sv
module ksched_top_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        start_en;
  logic [23:0] key_in;
  logic        ready;
  logic [7:0]  peek_addr;
  logic [7:0]  peek_data;

  int tests = 0;
  int fails = 0;
  logic [7:0] exp_s [256];

  always #4 clk = ~clk;

  ksched_top u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_en  (start_en),
    .key_in    (key_in),
    .ready     (ready),
    .peek_addr (peek_addr),
    .peek_data (peek_data)
  );

  task automatic model(input logic [23:0] k);
    logic [7:0] j, t, kb;
    for (int n = 0; n < 256; n++) exp_s[n] = 8'(n);
    j = 8'd0;
    for (int n = 0; n < 256; n++) begin
      kb = k[(2 - (n % 3))*8 +: 8];
      j = j + exp_s[n] + kb;
      t = exp_s[n]; exp_s[n] = exp_s[j]; exp_s[j] = t;
    end
  endtask

  task automatic check(input string req, input int act, input int expv);
    tests++;
    if (act != expv) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; start_en = 1'b0; peek_addr = 8'd0;
    repeat (3) @(negedge clk);
    check("R1 ready during reset", int'(ready), 1);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 ready after reset", int'(ready), 1);
  endtask

  // start, count busy cycles; optional disturbance at a given busy cycle
  task automatic run(input logic [23:0] k, input int disturb_at,
                     input logic [23:0] k2, output int busy);
    @(negedge clk);
    key_in = k; start_en = 1'b1;
    @(negedge clk);
    start_en = 1'b0;
    check("R2 ready low after accept", int'(ready), 0);
    busy = 0;
    while (!ready && busy < 5000) begin
      busy++;
      if (busy == disturb_at) begin key_in = k2; start_en = 1'b1; end
      else start_en = 1'b0;
      @(negedge clk);
    end
    start_en = 1'b0;
  endtask

  task automatic compare(input string req, input logic [23:0] k);
    int bad, first_a, first_v;
    model(k);
    bad = 0; first_a = -1; first_v = 0;
    for (int a = 0; a < 256; a++) begin
      peek_addr = 8'(a);
      @(negedge clk);
      if (peek_data != exp_s[a] && first_a < 0) begin
        first_a = a; first_v = int'(peek_data);
      end
      if (peek_data != exp_s[a]) bad++;
    end
    check(req, bad, 0);
    if (first_a >= 0)
      $display("  first mismatch at %0d: actual=%0d expected=%0d", first_a, first_v, exp_s[first_a]);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=timeout expected=finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin : main
    int busy;
    logic [23:0] k;
    void'($urandom(32'd20240611));
    key_in = 24'd0;
    do_reset();

    // R1/R7 idle: start_en ignored? no - idle accepts; check peek stability first (R8)
    run(24'h000000, 0, 24'h0, busy);
    check("R3 busy cycles key 000000", busy, 1280);
    compare("R4 array key 000000", 24'h000000);
    compare("R8 repeated read leaves memory intact", 24'h000000);

    run(24'hFFFFFF, 0, 24'h0, busy);
    check("R3 busy cycles key FFFFFF", busy, 1280);
    compare("R4 array key FFFFFF", 24'hFFFFFF);

    run(24'h01_02_03, 0, 24'h0, busy);
    compare("R5 byte order key 010203", 24'h010203);
    run(24'h00_00_5A, 0, 24'h0, busy);
    compare("R5 byte order key 00005A", 24'h00005A);

    for (int r = 0; r < 3; r++) begin
      k = 24'($urandom);
      run(k, 0, 24'h0, busy);
      check("R3 busy cycles random key", busy, 1280);
      compare("R4 array random key", k);
    end

    k = 24'h3C_A5_11;
    run(k, 600, 24'h7E_00_F0, busy);
    check("R7 busy cycles with start_en and key change mid-run", busy, 1280);
    compare("R6 key change mid-run ignored", k);

    k = 24'($urandom);
    run(k, 1279, 24'h123456, busy);
    check("R7 late start_en pulse busy cycles", busy, 1280);
    compare("R7 late start_en pulse ignored", k);

    // R9: reset in the middle of a run
    @(negedge clk);
    key_in = 24'hABCDEF; start_en = 1'b1;
    @(negedge clk);
    start_en = 1'b0;
    repeat (700) @(negedge clk);
    check("R9 busy before abort", int'(ready), 0);
    do_reset();
    k = 24'h0F1E2D;
    run(k, 0, 24'h0, busy);
    check("R9 busy cycles after abort", busy, 1280);
    compare("R9 array after abort", k);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule